// File: doc/BRIEF.md
# Armed two-edge period capture

This block measures how many base-clock cycles one period of a slow input signal lasts. A free-running counter advances on every base-clock cycle. After an arm pulse, the first accepted rising edge of the input stores the counter as the start stamp. The next accepted rising edge stores the stop stamp. The block then stops capturing and raises a done flag. From that point the period output holds the difference between the stop and start stamps until the next arm.

Before the input can produce an edge, it passes through a run-length glitch filter. The filtered level changes only after the raw input has shown the same value on four consecutive clock samples, so short spikes never reach the capture logic. The difference is taken modulo 2^32. A measurement that crosses one counter wrap therefore still gives the true cycle count. The reset value of the counter is a parameter.

Top module: `period_capture`

## Requirements
- R1: After reset, done and period are 0. Rising edges on the input have no effect until the first arm pulse.
- R2: An arm pulse returns the sequence to the wait-for-start step (step 0) and lowers done. This holds in any step, including a measurement in progress. A filtered rising edge in the same cycle as arm is not captured.
- R3: In step 0, a filtered rising edge stores the counter value as the start stamp and moves the sequence to step 1.
- R4: In step 1, the next filtered rising edge stores the stop stamp and moves the sequence to step 2. From then on, further input edges change neither done nor period until the next arm.
- R5: done is 1 exactly while the sequence is in step 2. While done is 0, period reads 0.
- R6: The filtered level changes only after 4 consecutive equal raw samples. A high pulse of 3 cycles is ignored. A high pulse of 4 cycles counts as a rising edge.
- R7: period equals the stop stamp minus the start stamp modulo 2^32. This also holds when the counter wrapped once between the two edges.
- R8: Only rising edges capture. For a square wave, period equals the full rise-to-rise spacing in clock cycles, whatever the duty cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock; the counter advances once per cycle |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | One-cycle pulse that starts or restarts a measurement |
| sig_in | input | 1 | Signal whose period is measured, synchronous to clk |
| done | output | 1 | High while a finished result is held |
| period | output | 32 | Stop stamp minus start stamp, 0 while not done |

## Verification
The input is driven with square waves of several periods and duty cycles. These show that the result is the rise-to-rise spacing and that falling edges play no part. One run starts the counter just below its top value, so that the start and stop stamps land on opposite sides of the wrap. Other runs test the sequence itself. Edges arrive before the first arm, after done, and between two arm pulses, which separates a restart from a continuation. Spikes of 3 cycles and pulses of exactly 4 cycles show where the filter starts to accept an edge.

// File: rtl/pcap_pkg.sv
package pcap_pkg;

    localparam int TS_W = 32;

    // Encoding follows the sequence step numbers; OFF is the idle state before any arm.
    typedef enum logic [1:0] {
        ST_WAIT_START = 2'd0,
        ST_WAIT_STOP  = 2'd1,
        ST_DONE       = 2'd2,
        ST_OFF        = 2'd3
    } step_e;

    typedef struct packed {
        logic [TS_W-1:0] start_ts;
        logic [TS_W-1:0] stop_ts;
    } stamps_t;

    // Modulo-2^TS_W distance; a single counter wrap cancels out.
    function automatic logic [TS_W-1:0] stamp_span(input stamps_t s);
        return s.stop_ts - s.start_ts;
    endfunction

endpackage

// File: rtl/pcap_filter.sv
module pcap_filter #(
    parameter int RUN_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level,
    output logic rise
);
    logic [RUN_LEN-1:0] hist;
    logic               level_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist    <= '0;
            level   <= 1'b0;
            level_d <= 1'b0;
        end else begin
            hist <= {hist[RUN_LEN-2:0], din};
            if (&hist)
                level <= 1'b1;
            else if (~|hist)
                level <= 1'b0;
            level_d <= level;
        end
    end

    assign rise = level & ~level_d;

endmodule

// File: rtl/pcap_timebase.sv
module pcap_timebase #(
    parameter int                     W    = 32,
    parameter logic [W-1:0]           INIT = '0
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] now
);
    always_ff @(posedge clk) begin
        if (rst)
            now <= INIT;
        else
            now <= now + 1'b1;
    end
endmodule

// File: rtl/pcap_sequencer.sv
module pcap_sequencer
    import pcap_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            arm,
    input  logic            rise,
    input  logic [TS_W-1:0] now,
    output step_e           step,
    output stamps_t         stamps
);
    always_ff @(posedge clk) begin
        if (rst) begin
            step   <= ST_OFF;
            stamps <= '0;
        end else if (arm) begin
            step <= ST_WAIT_START;
        end else begin
            case (step)
                ST_WAIT_START: if (rise) begin
                    stamps.start_ts <= now;
                    step            <= ST_WAIT_STOP;
                end
                ST_WAIT_STOP: if (rise) begin
                    stamps.stop_ts <= now;
                    step           <= ST_DONE;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/period_capture.sv
module period_capture
    import pcap_pkg::*;
#(
    parameter int              FILT_LEN = 4,
    parameter logic [TS_W-1:0] CNT_INIT = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            arm,
    input  logic            sig_in,
    output logic            done,
    output logic [TS_W-1:0] period
);
    logic            filt_level;
    logic            filt_rise;
    logic [TS_W-1:0] now;
    step_e           step;
    stamps_t         stamps;

    pcap_filter #(.RUN_LEN(FILT_LEN)) u_filt (
        .clk(clk), .rst(rst), .din(sig_in), .level(filt_level), .rise(filt_rise)
    );

    pcap_timebase #(.W(TS_W), .INIT(CNT_INIT)) u_tb (
        .clk(clk), .rst(rst), .now(now)
    );

    pcap_sequencer u_seq (
        .clk(clk), .rst(rst), .arm(arm), .rise(filt_rise), .now(now),
        .step(step), .stamps(stamps)
    );

    assign done   = (step == ST_DONE);
    assign period = done ? stamp_span(stamps) : '0;

endmodule

// File: rtl/pcap_checker.sv
module pcap_checker
    import pcap_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            arm,
    input logic            rise,
    input step_e           step,
    input logic            done,
    input logic [TS_W-1:0] period
);
    a_r1_off_until_arm: assert property (@(posedge clk) disable iff (rst)
        (step == ST_OFF && !arm) |=> (step == ST_OFF && !done));

    a_r2_arm_restarts: assert property (@(posedge clk) disable iff (rst)
        arm |=> (step == ST_WAIT_START && !done));

    a_r3_hold_without_edge: assert property (@(posedge clk) disable iff (rst)
        (step == ST_WAIT_START && !rise && !arm) |=> step == ST_WAIT_START);

    a_r3_start_on_edge: assert property (@(posedge clk) disable iff (rst)
        (step == ST_WAIT_START && rise && !arm) |=> step == ST_WAIT_STOP);

    a_r4_stop_on_edge: assert property (@(posedge clk) disable iff (rst)
        (step == ST_WAIT_STOP && rise && !arm) |=> done);

    a_r4_result_frozen: assert property (@(posedge clk) disable iff (rst)
        (done && !arm) |=> (done && $stable(period)));

    a_r5_done_needs_edge: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(rise));
endmodule

bind period_capture pcap_checker u_chk (
    .clk(clk), .rst(rst), .arm(arm), .rise(filt_rise),
    .step(step), .done(done), .period(period)
);

// File: tb/test_period_capture.sv
module test_period_capture;
    localparam logic [31:0] INIT = 32'hFFFF_FFD0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        arm = 1'b0;
    logic        sig_in = 1'b0;
    logic        done;
    logic [31:0] period;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    period_capture #(.FILT_LEN(4), .CNT_INIT(INIT)) i_period_capture (
        .clk(clk), .rst(rst), .arm(arm), .sig_in(sig_in), .done(done), .period(period)
    );

    // Behavioural reference: step 3 = idle, 0 wait start, 1 wait stop, 2 done.
    logic [31:0] m_cnt, m_start, m_stop;
    int          m_step;
    bit          m_q[$];
    bit          m_lvl, m_lvl_d;
    bit          wrap_seen;

    always @(posedge clk) begin : model
        bit r, all1, all0;
        if (rst) begin
            m_cnt = INIT; m_start = 0; m_stop = 0; m_step = 3;
            m_q = {1'b0, 1'b0, 1'b0, 1'b0}; m_lvl = 0; m_lvl_d = 0;
        end else begin
            r = m_lvl && !m_lvl_d;
            if (arm) m_step = 0;
            else if (m_step == 0 && r) begin m_start = m_cnt; m_step = 1; end
            else if (m_step == 1 && r) begin
                m_stop = m_cnt; m_step = 2;
                if (m_stop < m_start) wrap_seen = 1;
            end
            m_cnt = m_cnt + 1;
            m_lvl_d = m_lvl;
            all1 = 1; all0 = 1;
            foreach (m_q[i]) begin
                if (m_q[i]) all0 = 0; else all1 = 0;
            end
            if (all1) m_lvl = 1; else if (all0) m_lvl = 0;
            m_q.push_back(sig_in);
            void'(m_q.pop_front());
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (done !== (m_step == 2)) begin
                errors++;
                $display("FAIL R5 done act=%0b exp=%0b", done, m_step == 2);
            end
            checks++;
            if (period !== ((m_step == 2) ? m_stop - m_start : 32'd0)) begin
                errors++;
                $display("FAIL R7 period act=%0d exp=%0d", period,
                         (m_step == 2) ? m_stop - m_start : 32'd0);
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic hold(input bit lv, input int n);
        sig_in = lv;
        repeat (n) @(negedge clk);
    endtask

    task automatic wave(input int hi, input int lo, input int n);
        for (int k = 0; k < n; k++) begin
            hold(1'b1, hi);
            hold(1'b0, lo);
        end
    endtask

    task automatic do_arm;
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 50000) begin
            errors++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset done", {31'd0, done}, 32'd0);
        chk("R1 reset period", period, 32'd0);
        wave(5, 5, 2);
        hold(1'b0, 6);
        chk("R1 edges before arm", {31'd0, done}, 32'd0);

        // Measurement straddling the counter wrap.
        do_arm();
        wave(30, 30, 2);
        chk("R4 done after two edges", {31'd0, done}, 32'd1);
        chk("R7 wrapped period", period, 32'd60);
        chk("R7 stamps straddled wrap", {31'd0, wrap_seen}, 32'd1);

        wave(10, 10, 3);
        chk("R4 later edges ignored", period, 32'd60);

        do_arm();
        chk("R2 arm clears done", {31'd0, done}, 32'd0);
        wave(10, 30, 3);
        chk("R8 uneven duty period", period, 32'd40);

        hold(1'b0, 10);
        do_arm();
        wave(20, 20, 1);
        chk("R3 one edge not done", {31'd0, done}, 32'd0);
        do_arm();
        wave(15, 15, 3);
        chk("R2 rearm restarts", period, 32'd30);

        do_arm();
        hold(1'b1, 3); hold(1'b0, 10);
        hold(1'b1, 3); hold(1'b0, 10);
        wave(25, 25, 2);
        chk("R6 glitches ignored", period, 32'd50);

        do_arm();
        hold(1'b1, 4); hold(1'b0, 20);
        hold(1'b1, 20); hold(1'b0, 10);
        chk("R6 four-cycle pulse accepted", period, 32'd24);

        summary();
        $finish;
    end
endmodule